// File: doc/BRIEF.md
# Module Power Mode Controller

This block chooses the power mode that a cable-end device may run in. It combines four request sources (a power-override control bit, a power-set control bit, a power-down control bit and a low-power pin) with a two-bit power class that the device declares. From these it derives a low-power or high-power state, an encoded allowed power level, and enables for the transmit and receive paths.

A mode change is a timed transition. The transition is counted in ticks of a slow time base, such as a 1 us strobe. The controller raises a busy flag for the whole transition. It holds the mode, level and path enables steady until the final tick, then applies the new state on that edge. Entry to low power takes a short window when the pin requested it and a longer window when a control bit did. The return to high power takes its own window. Each window is a parameter, so it can be set below the limit the system requires.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, high_pwr_o, level_o, tx_en_o, rx_en_o and busy_o are all 0.
- R2: When the override bit is 0, the requested mode is low power (high_pwr_o settles to 0).
- R3: When the power-set bit is 1, the requested mode is low power whatever the override bit is, and the block never leaves low power while the bit is held.
- R4: In high power, level_o equals the declared class: code 0 = 1.5 W, 1 = 2.0 W, 2 = 2.5 W, 3 = 3.5 W.
- R5: In low power, level_o is 0 (1.5 W).
- R6: With class 0, tx_en_o and rx_en_o are both 1 in low and in high power once reset has ended.
- R7: With a class above 0 in low power, tx_en_o and rx_en_o are both 0. This includes the state that follows reset.
- R8: An entry into low power caused by the pin completes on the PIN_TICKS-th tick after the transition starts.
- R9: An entry into low power caused only by control bits (override low, power-set or power-down) completes on the LOW_TICKS-th tick.
- R10: A return to high power completes on the HIGH_TICKS-th tick.
- R11: busy_o is 1 from the edge that starts a transition until the edge that completes it. While it is 1, high_pwr_o, level_o and the enables do not change before the completing edge.
- R12: Only tick pulses advance a transition. Clock cycles without a tick leave busy_o at 1 and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one cycle wide |
| ovr_i | input | 1 | Power-override control bit |
| pset_i | input | 1 | Power-set control bit (forces low power) |
| pdown_i | input | 1 | Power-down control bit |
| lpm_pin_i | input | 1 | Low-power pin, active high |
| pclass_i | input | 2 | Declared maximum power class |
| high_pwr_o | output | 1 | 1 = high-power mode |
| level_o | output | 2 | Allowed power level code |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| busy_o | output | 1 | Mode transition in progress |

## Verification
A wrong internal goal or a wrong count shows up at the ports as a wrong number of ticks between the rise and the fall of busy_o. It can also show up as a mode on high_pwr_o that disagrees with the request. Either appears at the latest at the end of the transition. A wrong level or enable decode differs from the reference in the first idle cycle after the mode or class settles. The bench compares every output with its model on every clock, so any divergence is reported on the cycle it occurs. It also measures each transition length in ticks.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    CAUSE_PIN  = 2'd0,
    CAUSE_REG  = 2'd1,
    CAUSE_WAKE = 2'd2
  } pm_cause_e;

  // Low power is requested by any of the four sources.
  function automatic logic wants_low(input logic ovr, input logic pset,
                                     input logic pdown, input logic pin);
    return (~ovr) | pset | pdown | pin;
  endfunction

  // Level code: 0=1.5W 1=2.0W 2=2.5W 3=3.5W; low power is always code 0.
  function automatic logic [1:0] allowed_level(input logic hi, input logic [1:0] cls);
    return hi ? cls : 2'b00;
  endfunction

  // A path runs in high power, for class 0, or when it is never shed.
  function automatic logic path_on(input logic hi, input logic [1:0] cls, input logic shed);
    return hi | (cls == 2'b00) | ~shed;
  endfunction

endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
(
  input  logic      ovr_i,
  input  logic      pset_i,
  input  logic      pdown_i,
  input  logic      lpm_pin_i,
  input  logic      mode_hi_i,
  output logic      goal_hi_o,
  output logic      change_o,
  output pm_cause_e cause_o
);
  logic low_req_w;

  always_comb begin
    low_req_w = wants_low(ovr_i, pset_i, pdown_i, lpm_pin_i);
    goal_hi_o = ~low_req_w;
    change_o  = goal_hi_o != mode_hi_i;
    if (goal_hi_o)      cause_o = CAUSE_WAKE;
    else if (lpm_pin_i) cause_o = CAUSE_PIN;
    else                cause_o = CAUSE_REG;
  end
endmodule

// File: rtl/pwr_mode_timer.sv
module pwr_mode_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q & tick_i & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_i;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R12: cycles without a tick leave the remaining count alone
  p_count_waits_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick_i && !start_i |=> $stable(cnt_q) && busy_q);

  // R11: a transition never starts on top of another one
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start_i);
endmodule

// File: rtl/pwr_mode_drive.sv
module pwr_mode_drive
  import pwr_mode_pkg::*;
#(
  parameter bit SHED_TX = 1'b1,
  parameter bit SHED_RX = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_i,
  input  logic       mode_next_i,
  input  logic [1:0] pclass_i,
  input  logic       busy_i,
  output logic       high_pwr_o,
  output logic [1:0] level_o,
  output logic       tx_en_o,
  output logic       rx_en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_pwr_o <= 1'b0;
      level_o    <= 2'b00;
      tx_en_o    <= 1'b0;
      rx_en_o    <= 1'b0;
    end else if (upd_i) begin
      high_pwr_o <= mode_next_i;
      level_o    <= allowed_level(mode_next_i, pclass_i);
      tx_en_o    <= path_on(mode_next_i, pclass_i, SHED_TX);
      rx_en_o    <= path_on(mode_next_i, pclass_i, SHED_RX);
    end
  end

  // R5: low power always reports the base level
  p_low_is_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !high_pwr_o |-> level_o == 2'b00);

  // R6: class 0 keeps both paths running when idle
  p_class0_paths_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !busy_i && $past(!busy_i) && $past(pclass_i) == 2'b00
    |-> tx_en_o && rx_en_o);

  // R7: higher classes shed the paths in low power
  p_shed_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !busy_i && !high_pwr_o && $past(pclass_i) != 2'b00
    |-> (SHED_TX ? !tx_en_o : 1'b1) && (SHED_RX ? !rx_en_o : 1'b1));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int PIN_TICKS  = 100,
  parameter int LOW_TICKS  = 100000,
  parameter int HIGH_TICKS = 300000,
  parameter bit SHED_TX    = 1'b1,
  parameter bit SHED_RX    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ovr_i,
  input  logic       pset_i,
  input  logic       pdown_i,
  input  logic       lpm_pin_i,
  input  logic [1:0] pclass_i,
  output logic       high_pwr_o,
  output logic [1:0] level_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       busy_o
);
  localparam int MAX_A = (PIN_TICKS > LOW_TICKS) ? PIN_TICKS : LOW_TICKS;
  localparam int MAX_T = (MAX_A > HIGH_TICKS) ? MAX_A : HIGH_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             goal_hi_w;
  logic             change_w;
  pm_cause_e        cause_w;
  logic             start_w;
  logic             done_w;
  logic             upd_w;
  logic             mode_next_w;
  logic             goal_q;
  logic [CNT_W-1:0] load_w;

  pwr_mode_decode u_decode (
    .ovr_i     (ovr_i),
    .pset_i    (pset_i),
    .pdown_i   (pdown_i),
    .lpm_pin_i (lpm_pin_i),
    .mode_hi_i (high_pwr_o),
    .goal_hi_o (goal_hi_w),
    .change_o  (change_w),
    .cause_o   (cause_w)
  );

  always_comb begin
    unique case (cause_w)
      CAUSE_PIN:  load_w = CNT_W'(PIN_TICKS);
      CAUSE_REG:  load_w = CNT_W'(LOW_TICKS);
      default:    load_w = CNT_W'(HIGH_TICKS);
    endcase
  end

  assign start_w     = change_w & ~busy_o;
  assign upd_w       = ~busy_o | done_w;
  assign mode_next_w = done_w ? goal_q : high_pwr_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       goal_q <= 1'b0;
    else if (start_w) goal_q <= goal_hi_w;
  end

  pwr_mode_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_w),
    .load_i  (load_w),
    .tick_i  (tick_i),
    .busy_o  (busy_o),
    .done_o  (done_w)
  );

  pwr_mode_drive #(.SHED_TX(SHED_TX), .SHED_RX(SHED_RX)) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (upd_w),
    .mode_next_i (mode_next_w),
    .pclass_i    (pclass_i),
    .busy_i      (busy_o),
    .high_pwr_o  (high_pwr_o),
    .level_o     (level_o),
    .tx_en_o     (tx_en_o),
    .rx_en_o     (rx_en_o)
  );

  // R11: outputs frozen while a transition is under way
  p_hold_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_w |=> $stable({high_pwr_o, level_o, tx_en_o, rx_en_o}));

  // R10: high power is only ever entered through a timed transition
  p_rise_timed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(high_pwr_o) |-> $past(busy_o) && !busy_o);

  // R3: power-set held in low power keeps the block there
  p_pset_holds_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pset_i && !busy_o && !high_pwr_o |=> !high_pwr_o);

  // R12: a transition only ends on a tick
  p_end_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_i));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PIN_T  = 3;
  localparam int LOW_T  = 6;
  localparam int HIGH_T = 9;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
  logic ovr_i = 1'b0, pset_i = 1'b0, pdown_i = 1'b0, lpm_pin_i = 1'b0;
  logic [1:0] pclass_i = 2'd2;
  logic high_pwr_o, tx_en_o, rx_en_o, busy_o;
  logic [1:0] level_o;

  pwr_mode_ctrl #(.PIN_TICKS(PIN_T), .LOW_TICKS(LOW_T), .HIGH_TICKS(HIGH_T)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ovr_i(ovr_i), .pset_i(pset_i),
    .pdown_i(pdown_i), .lpm_pin_i(lpm_pin_i), .pclass_i(pclass_i),
    .high_pwr_o(high_pwr_o), .level_o(level_o), .tx_en_o(tx_en_o),
    .rx_en_o(rx_en_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: remaining ticks held as an integer
  bit m_hi, m_busy, m_goal, m_tx, m_rx;
  int m_lvl, m_left;

  task automatic m_refresh();
    m_lvl = m_hi ? int'(pclass_i) : 0;
    m_tx  = m_hi || pclass_i == 2'd0;
    m_rx  = m_tx;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_busy = 0; m_goal = 0; m_tx = 0; m_rx = 0; m_lvl = 0; m_left = 0;
    end else if (m_busy) begin
      if (tick_i) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_hi = m_goal; m_busy = 0; m_refresh();
        end
      end
    end else begin
      bit low_wanted;
      low_wanted = !ovr_i || pset_i || pdown_i || lpm_pin_i;
      m_refresh();
      if (low_wanted == m_hi) begin
        m_goal = !low_wanted;
        m_left = m_goal ? HIGH_T : (lpm_pin_i ? PIN_T : LOW_T);
        m_busy = 1;
      end
    end
  end

  // per-clock comparison, tick generation and transition length measurement
  bit tick_run = 0;
  int tick_gap = 2;
  int cyc = 0;
  bit prev_busy = 0;
  int tcount = 0, last_len = 0, ends_seen = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R11", busy_o, m_busy, "busy");
      check("R2", high_pwr_o, m_hi, "mode");
      check("R4", level_o, m_lvl, "level");
      check("R7", tx_en_o, m_tx, "tx_en");
      check("R7", rx_en_o, m_rx, "rx_en");
    end
    if (prev_busy && tick_i) tcount++;
    if (prev_busy && !busy_o) begin
      last_len = tcount;
      ends_seen++;
    end
    if (!busy_o) tcount = 0;
    prev_busy = busy_o;
    tick_i = tick_run && (cyc % tick_gap == 0);
    cyc++;
  end

  task automatic expect_transition(input string req, input int n);
    int start_ends;
    start_ends = ends_seen;
    while (ends_seen == start_ends) @(posedge clk);
    @(negedge clk);
    check(req, last_len, n, "ticks in transition");
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    settle(2);
    // R1 reset values
    check("R1", high_pwr_o, 0, "mode in reset");
    check("R1", level_o, 0, "level in reset");
    check("R1", tx_en_o + rx_en_o, 0, "enables in reset");
    check("R1", busy_o, 0, "busy in reset");
    rst_n = 1'b1;
    tick_run = 1;
    settle(2);
    check("R7", tx_en_o, 0, "tx after reset class 2");
    check("R2", high_pwr_o, 0, "low with override 0");

    ovr_i = 1'b1;
    expect_transition("R10", HIGH_T);
    check("R4", level_o, 2, "level class 2");
    check("R4", tx_en_o & rx_en_o, 1, "paths on in high");

    pset_i = 1'b1;
    expect_transition("R9", LOW_T);
    check("R3", high_pwr_o, 0, "power-set forces low");
    check("R5", level_o, 0, "base level in low");
    check("R7", tx_en_o | rx_en_o, 0, "paths shed");
    settle(8);
    check("R3", high_pwr_o, 0, "stays low under power-set");

    pset_i = 1'b0;
    expect_transition("R10", HIGH_T);
    tick_gap = 3;
    lpm_pin_i = 1'b1;
    expect_transition("R8", PIN_T);
    check("R8", high_pwr_o, 0, "pin entry low");
    lpm_pin_i = 1'b0;
    expect_transition("R10", HIGH_T);
    pdown_i = 1'b1;
    expect_transition("R9", LOW_T);
    pdown_i = 1'b0;
    expect_transition("R10", HIGH_T);

    pclass_i = 2'd3;
    settle(2);
    check("R4", level_o, 3, "level class 3");
    pclass_i = 2'd1;
    settle(2);
    check("R4", level_o, 1, "level class 1");

    tick_run = 0;
    ovr_i = 1'b0;
    settle(20);
    check("R12", busy_o, 1, "busy held without ticks");
    check("R11", high_pwr_o, 1, "mode held mid transition");
    tick_run = 1;
    tick_gap = 2;
    expect_transition("R2", LOW_T);
    check("R2", high_pwr_o, 0, "override low gives low");

    pclass_i = 2'd0;
    settle(3);
    check("R6", tx_en_o & rx_en_o, 1, "class 0 paths in low");
    ovr_i = 1'b1;
    settle(3);
    check("R11", busy_o, 1, "busy during wake");
    check("R6", tx_en_o & rx_en_o, 1, "class 0 paths during wake");
    expect_transition("R10", HIGH_T);
    check("R6", tx_en_o & rx_en_o, 1, "class 0 paths in high");
    check("R4", level_o, 0, "class 0 level in high");

    settle(4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule